// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter

This block decides which of several bus masters may drive a shared parallel bus next. Each master raises an active-low bid line. The arbiter watches the two active-low bus-activity signals: the transaction-framing line and the initiator-ready line. It drives one active-low grant line per master. The bus counts as idle only when both activity lines are high. The grant never covers more than one master at a time. When the grant moves, it moves from one master to another within a single clock.

Bids and activity lines pass through one register stage before any decision uses them. Grants come straight from flip-flops. A small state machine holds the grant and has three states:

- **ARB_OFF**: entered only by reset; no grant is driven.
- **ARB_PARK**: no master is bidding, so the grant rests on master 0.
- **ARB_OWN**: a bidding master holds the grant.

The transitions are:

- **T_FIRST**: ARB_OFF to ARB_PARK or ARB_OWN, on the first clock after reset.
- **T_STAY_PARK**: ARB_PARK to ARB_PARK while no master bids.
- **T_WAKE**: ARB_PARK to ARB_OWN when a bid appears.
- **T_HOLD**: ARB_OWN to ARB_OWN while the owner keeps bidding and the bus is not idle.
- **T_RELEASE**: ARB_OWN to ARB_OWN with a new owner when the owner drops its bid and others are bidding.
- **T_PREEMPT_IDLE**: ARB_OWN to ARB_OWN with a new owner when the bus is idle and another master bids.
- **T_TO_PARK**: ARB_OWN to ARB_PARK when nobody bids.

A decision searches the registered bids in fixed order. The search starts one position after the last real winner and wraps around. As a result, the master that won most recently has the lowest priority. The rotation pointer moves only when a decision picks a winner. It does not move on every clock of a transaction, and parking does not move it.

Top module: `pci_rr_arbiter`

## Requirements
- R1: While reset is low, every grant_n bit is 1. Reset leaves the rotation pointer on master N-1, so master 0 has the highest priority at the first decision.
- R2: In any cycle, at most one grant_n bit is 0.
- R3: A change on bid_n, xfer_n or init_rdy_n can first affect grant_n at the second rising clock edge after it is applied.
- R4: While the owner keeps bidding and the bus is not idle, grant_n does not change, whatever the other masters bid.
- R5: The bus is idle only when xfer_n and init_rdy_n are both 1. With xfer_n at 1 and init_rdy_n at 0, the owner keeps the grant as in R4.
- R6: When the owner drops its bid, the grant goes to the first bidding master found by searching upward from owner+1 with wrap-around. The old owner is considered last.
- R7: When the bus is idle, the owner is still bidding and another master bids, the grant moves to the first other bidder after the owner in the same wrap-around order.
- R8: When no master bids, the grant is parked on master 0, so grant_n = all ones except bit 0 = 0.
- R9: Parking does not move the rotation pointer. The next decision searches from one position after the last real winner.
- R10: From the first rising edge after reset is released, exactly one grant_n bit is 0 in every cycle. A handover replaces one grant with the other in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bid_n | input | N | Per-master bus request, active low |
| xfer_n | input | 1 | Transaction framing line, active low |
| init_rdy_n | input | 1 | Initiator ready line, active low |
| grant_n | output | N | Per-master grant, active low, at most one low |

## Verification
A wrong state or a wrong rotation pointer in this arbiter shows up on grant_n as a grant given to the wrong master. Because of the input register, this appears at the second edge after the stimulus that should have caused a decision. A pointer that rotates too often, or that is moved by parking, stays hidden until the next real decision. That decision then picks a different bidder from the one the wrap-around search predicts, so the sweeps hold each bid and bus pattern for several cycles and then change it. An idle test that looks at xfer_n alone shows up only when init_rdy_n is low while xfer_n is high: the grant then moves away from a master that is still bidding.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ARB_OFF  = 2'd0,
        ARB_PARK = 2'd1,
        ARB_OWN  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/arb_in_reg.sv
module arb_in_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] bid_n,
    input  logic         xfer_n,
    input  logic         init_rdy_n,
    output logic [N-1:0] bid_q,
    output logic         idle_q
);
    // One register stage; converts to active-high bids.
    // The bus is idle only when both activity lines are high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bid_q  <= '0;
            idle_q <= 1'b0;
        end else begin
            bid_q  <= ~bid_n;
            idle_q <= xfer_n & init_rdy_n;
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  bids,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] win
);
    // Fixed-priority search that starts one slot after the last winner.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 1; k <= N; k++) begin
            int t;
            t = (int'(last) + k) % N;
            if (!found && bids[t]) begin
                found = 1'b1;
                win   = IW'(t);
            end
        end
    end
endmodule

// File: rtl/pci_rr_arbiter.sv
module pci_rr_arbiter
    import arb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] bid_n,
    input  logic         xfer_n,
    input  logic         init_rdy_n,
    output logic [N-1:0] grant_n
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST_RST = IW'(N - 1);

    logic [N-1:0]  bid_q;
    logic          idle_q;
    arb_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;
    logic [IW-1:0] last_q, last_d;
    logic [N-1:0]  grant_q;
    logic          found;
    logic [IW-1:0] win;
    logic [N-1:0]  own_mask;
    logic          decide;

    arb_in_reg #(.N(N)) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .bid_n      (bid_n),
        .xfer_n     (xfer_n),
        .init_rdy_n (init_rdy_n),
        .bid_q      (bid_q),
        .idle_q     (idle_q)
    );

    arb_rr_pick #(.N(N), .IW(IW)) u_pick (
        .bids  (bid_q),
        .last  (last_q),
        .found (found),
        .win   (win)
    );

    assign own_mask = N'(1) << owner_q;

    // Decision condition per state
    always_comb begin
        unique case (state_q)
            ARB_OFF:  decide = 1'b1;                         // T_FIRST
            ARB_PARK: decide = |bid_q;                       // T_WAKE / T_STAY_PARK
            ARB_OWN:  decide = !(|(bid_q & own_mask)) ||     // T_RELEASE / T_TO_PARK
                               (idle_q && |(bid_q & ~own_mask)); // T_PREEMPT_IDLE
            default:  decide = 1'b1;
        endcase
    end

    // Next state, owner and rotation pointer
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        last_d  = last_q;
        if (decide) begin
            if (found) begin
                state_d = ARB_OWN;
                owner_d = win;
                last_d  = win;
            end else begin
                state_d = ARB_PARK;
                owner_d = '0;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_OFF;
            owner_q <= '0;
            last_q  <= LAST_RST;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            last_q  <= last_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else begin
            unique case (state_d)
                ARB_OWN:  grant_q <= N'(1) << owner_d;
                ARB_PARK: grant_q <= N'(1);
                default:  grant_q <= '0;
            endcase
        end
    end

    assign grant_n = ~grant_q;
endmodule

// File: rtl/pci_arb_chk.sv
module pci_arb_chk
    import arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  grant_n,
    input logic [N-1:0]  bid_q,
    input logic          idle_q,
    input arb_state_e    state_q,
    input logic [IW-1:0] owner_q
);
    logic up;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up <= 1'b0;
        else        up <= 1'b1;
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (grant_n == {N{1'b1}});
        end
    end

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~grant_n));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_OWN && bid_q[owner_q] && !idle_q) |=> $stable(grant_n));

    // R8
    park_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bid_q == '0) |=> (grant_n == ~N'(1)));

    // R10
    always_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> ($countones(~grant_n) == 1));
endmodule

bind pci_rr_arbiter pci_arb_chk #(.N(N), .IW(IW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant_n (grant_n),
    .bid_q   (bid_q),
    .idle_q  (idle_q),
    .state_q (state_q),
    .owner_q (owner_q)
);

// File: tb/sim_pci_rr_arbiter.sv
`timescale 1ns/1ps
module sim_pci_rr_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] bid_n = '1;
    logic         xfer_n = 1'b1;
    logic         init_rdy_n = 1'b1;
    logic [N-1:0] grant_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state: 0 off, 1 park, 2 own
    int           m_state = 0;
    int           m_own = 0;
    int           m_last = N - 1;
    logic [N-1:0] m_bid = '0;
    logic         m_idle = 1'b0;
    logic [N-1:0] m_gnt = '0;

    always #5 clk = ~clk;

    pci_rr_arbiter #(.N(N)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bid_n      (bid_n),
        .xfer_n     (xfer_n),
        .init_rdy_n (init_rdy_n),
        .grant_n    (grant_n)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s grant_n actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit dec;
        bit fnd;
        int w;
        logic [N-1:0] om;
        om = N'(1) << m_own;
        case (m_state)
            0: dec = 1'b1;
            1: dec = |m_bid;
            default: dec = !(|(m_bid & om)) || (m_idle && |(m_bid & ~om));
        endcase
        if (dec) begin
            fnd = 1'b0;
            w = 0;
            for (int k = 1; k <= N; k++) begin
                int t;
                t = (m_last + k) % N;
                if (!fnd && m_bid[t]) begin
                    fnd = 1'b1;
                    w = t;
                end
            end
            if (fnd) begin
                m_state = 2; m_own = w; m_last = w;
                m_gnt = N'(1) << w;
            end else begin
                m_state = 1; m_own = 0;
                m_gnt = N'(1);
            end
        end
    endtask

    // drive at negedge, let one rising edge pass, compare at next negedge
    task automatic step(input logic [N-1:0] b, input logic f, input logic r, input string tag);
        bid_n = b; xfer_n = f; init_rdy_n = r;
        @(posedge clk);
        model_edge();
        m_bid = ~b;
        m_idle = f & r;
        @(negedge clk);
        chk(tag, grant_n, ~m_gnt);
        checks++;
        if ($countones(~grant_n) > 1) begin
            failures++;
            $display("FAIL R2 grant_n actual=%b expected=at most one low", grant_n);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", grant_n, 4'b1111);
        rst_n = 1'b1;
        // first edge after reset: parked on master 0
        step(4'b1111, 1'b1, 1'b1, "R10");
        chk("R8", grant_n, 4'b1110);

        // masters 1 and 2 bid, bus busy
        step(4'b1001, 1'b0, 1'b0, "R3");
        chk("R3", grant_n, 4'b1110);     // only one edge since the bids appeared
        step(4'b1001, 1'b0, 1'b0, "R1");
        chk("R1", grant_n, 4'b1101);     // pointer at 3, so master 1 wins
        repeat (3) step(4'b1001, 1'b0, 1'b0, "R4");
        chk("R4", grant_n, 4'b1101);
        // master 1 drops, master 3 joins: search after 1 finds 2
        step(4'b0011, 1'b0, 1'b0, "R6");
        step(4'b0011, 1'b0, 1'b0, "R6");
        chk("R6", grant_n, 4'b1011);
        // framing high, ready low: not idle, owner keeps grant
        repeat (3) step(4'b0011, 1'b1, 1'b0, "R5");
        chk("R5", grant_n, 4'b1011);
        // both high: idle, move to 3
        step(4'b0011, 1'b1, 1'b1, "R7");
        step(4'b0011, 1'b0, 1'b0, "R7");
        chk("R7", grant_n, 4'b0111);
        // all release: park
        repeat (2) step(4'b1111, 1'b0, 1'b0, "R8");
        chk("R8", grant_n, 4'b1110);
        // masters 0 and 1 bid: pointer still at 3, so 0 wins
        repeat (2) step(4'b1100, 1'b0, 1'b0, "R9");
        chk("R9", grant_n, 4'b1110);
        // master 0 drops: 1 next
        repeat (2) step(4'b1101, 1'b0, 1'b0, "R6");
        chk("R6", grant_n, 4'b1101);

        // sweep of every bid pattern and bus state, held several cycles
        for (int p = 0; p < 16; p++)
            for (int b = 0; b < 4; b++)
                repeat (3) step(4'(p), b[1], b[0], "R3");
        for (int p = 0; p < 16; p++)
            for (int b = 0; b < 4; b++)
                repeat (2) step(4'((p * 7 + 3) % 16), b[0], b[1], "R6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule